// File: doc/BRIEF.md
# Indirect PHY Register Access Engine

This block is a bus master that carries out single reads and writes of internal PHY control registers. The registers cannot be reached directly. Each one is reached through a paged window on a memory-mapped bus, behind a small command port made of a control register, an address register and a data register. A client presents one request at a time on a valid/ready interface. The request carries a PHY index, a 16-bit internal register address, write data and a direction flag. The engine then runs the whole multi-transaction sequence on the bus by itself.

Each PHY instance owns a fixed stride of the bus address space. A page register sits at a fixed offset inside that stride. Before every access through the window, the engine writes the page register with a device select and the upper bits of the internal address. It then issues the window access at an address formed from the lower nine bits. The engine polls the busy bit of the command port before each command, and again before fetching read data. Every busy poll has an upper bound on the number of busy reads. Reaching that bound ends the request with an error.

Top module: `phy_indirect_access`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `bus_req`, `rsp_done` and `rsp_err` are 0.
- R2: Every window access is immediately preceded by a bus write to the page register of the same PHY, at address BASE + phy*STRIDE + PAGE_OFS. The value written is (dev << 7) | (reg_addr >> 9) with dev taken as 5 bits.
- R3: A window access goes to BASE + phy*STRIDE + ((reg_addr & 0x1FF) << 2). That offset is word aligned and lies below PAGE_OFS.
- R4: The device select is 31 for PHY index 5 and 5 for every other index.
- R5: A read runs these steps in order: busy poll, write of the target address to register 0x80A1, write of 0x0001 to control 0x80A0, busy poll, read of data register 0x80A2. `rsp_rdata` then carries the word returned by that last read.
- R6: A write runs these steps in order: busy poll, address to 0x80A1, data to 0x80A2, 0x0003 to control 0x80A0. The response follows that last control write with no further polling.
- R7: A busy poll reads control register 0x80A0. It reads again while bit 0 is 1 and stops at the first read with bit 0 equal to 0.
- R8: When a single poll sees POLL_LIMIT consecutive busy reads, the engine issues no further transactions. It pulses `rsp_done` with `rsp_err`=1, returns to ready, and then serves new requests normally.
- R9: `req_ready` is 1 exactly when no request is outstanding. A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. `req_valid` has no effect while a request is outstanding. `rsp_done` is a one-cycle pulse and `rsp_err` is 1 only alongside it.
- R10: Once raised, `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle that `bus_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | PHY_W | PHY instance index |
| req_addr | input | 16 | Internal PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Busy-poll timeout, valid with `rsp_done` |
| rsp_rdata | output | 32 | Data register word returned by a read |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus transaction complete |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The assertions check, on every cycle, the bus holding rule and the request handshake. They also check that `rsp_done` is a single-cycle pulse with `rsp_err` riding on it, that a page write follows each completed window access, and that the poll counter stays bounded. The content of the traffic can only be shown by the bench's scenarios. That content covers the page values and window addresses for each PHY, the per-direction step order, the number of polls against a PHY model whose busy time follows a write, the timeouts in the first and second poll, and the ignored requests made while busy. The bench checks these by rebuilding each internal access from the bus traffic and comparing it with the expected order.

// File: rtl/phy_indirect_access_pkg.sv
package phy_indirect_access_pkg;

  localparam int REG_W  = 16;
  localparam int BUS_DW = 32;
  localparam int DEV_W  = 5;

  localparam logic [REG_W-1:0] REG_CMD  = 16'h80A0;
  localparam logic [REG_W-1:0] REG_ADR  = 16'h80A1;
  localparam logic [REG_W-1:0] REG_DAT  = 16'h80A2;

  localparam logic [BUS_DW-1:0] CMD_GO    = 32'h0000_0001;
  localparam logic [BUS_DW-1:0] CMD_GO_WR = 32'h0000_0003;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAGE,
    ST_ACC
  } eng_state_t;

  typedef enum logic [2:0] {
    SP_POLL_PRE,
    SP_ADDR,
    SP_DATA,
    SP_CMD,
    SP_POLL_POST,
    SP_FETCH
  } eng_step_t;

  function automatic logic [REG_W-1:0] step_reg(eng_step_t s);
    case (s)
      SP_ADDR:  step_reg = REG_ADR;
      SP_DATA:  step_reg = REG_DAT;
      SP_FETCH: step_reg = REG_DAT;
      default:  step_reg = REG_CMD;
    endcase
  endfunction

endpackage

// File: rtl/phy_indirect_map.sv
module phy_indirect_map
  import phy_indirect_access_pkg::*;
#(
  parameter int                NUM_PHY  = 6,
  parameter int                PHY_W    = 3,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BASE     = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] STRIDE   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] PAGE_OFS = 32'h0000_0800,
  parameter int                DEV_STD  = 5,
  parameter int                DEV_ALT  = 31,
  parameter int                ALT_PHY  = 5
) (
  input  logic [PHY_W-1:0]  phy_idx,
  input  logic [REG_W-1:0]  reg_addr,
  output logic [ADDR_W-1:0] page_addr,
  output logic [BUS_DW-1:0] page_val,
  output logic [ADDR_W-1:0] win_addr
);

  localparam int PAD_PAGE = BUS_DW - DEV_W - 7;
  localparam int PAD_WIN  = ADDR_W - 11;

  logic [ADDR_W-1:0] base_tbl [NUM_PHY];
  logic [ADDR_W-1:0] sel_base;
  logic [DEV_W-1:0]  dev;

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_base
    assign base_tbl[g] = BASE + ADDR_W'(g) * STRIDE;
  end

  always_comb begin
    sel_base = BASE;
    for (int k = 0; k < NUM_PHY; k++) begin
      if (phy_idx == PHY_W'(k)) sel_base = base_tbl[k];
    end
  end

  assign dev       = (phy_idx == PHY_W'(ALT_PHY)) ? DEV_W'(DEV_ALT) : DEV_W'(DEV_STD);
  assign page_addr = sel_base + PAGE_OFS;
  assign page_val  = {{PAD_PAGE{1'b0}}, dev, reg_addr[15:9]};
  assign win_addr  = sel_base + {{PAD_WIN{1'b0}}, reg_addr[8:0], 2'b00};

endmodule

// File: rtl/phy_indirect_poll_timer.sv
module phy_indirect_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic busy_seen,
  output logic at_limit
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (busy_seen) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT - 1));

  // R8: the busy count never reaches the limit without being cleared
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/phy_indirect_seq.sv
module phy_indirect_seq
  import phy_indirect_access_pkg::*;
#(
  parameter int PHY_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic [PHY_W-1:0]  map_phy,
  output logic [REG_W-1:0]  map_reg,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic [BUS_DW-1:0] page_val,
  input  logic [ADDR_W-1:0] win_addr,
  output logic              tm_clr,
  output logic              tm_busy,
  input  logic              tm_at_limit
);

  eng_state_t        state;
  eng_step_t         step, nxt_step;
  logic              lat_write;
  logic [PHY_W-1:0]  lat_phy;
  logic [REG_W-1:0]  lat_addr, lat_wdata;
  logic              go_page, go_acc, finish, fail;
  logic              acc_we;
  logic [BUS_DW-1:0] acc_wdata;

  always_comb begin
    nxt_step = step;
    go_page  = 1'b0;
    go_acc   = 1'b0;
    finish   = 1'b0;
    fail     = 1'b0;
    tm_clr   = 1'b0;
    tm_busy  = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        nxt_step = SP_POLL_PRE;
        go_page  = 1'b1;
        tm_clr   = 1'b1;
      end
      ST_PAGE: if (bus_ack) go_acc = 1'b1;
      ST_ACC: if (bus_ack) begin
        case (step)
          SP_POLL_PRE, SP_POLL_POST: begin
            if (bus_rdata[0]) begin
              tm_busy = 1'b1;
              if (tm_at_limit) begin
                fail   = 1'b1;
                tm_clr = 1'b1;
              end else begin
                go_page = 1'b1;
              end
            end else begin
              tm_clr   = 1'b1;
              go_page  = 1'b1;
              nxt_step = (step == SP_POLL_PRE) ? SP_ADDR : SP_FETCH;
            end
          end
          SP_ADDR: begin
            go_page  = 1'b1;
            nxt_step = lat_write ? SP_DATA : SP_CMD;
          end
          SP_DATA: begin
            go_page  = 1'b1;
            nxt_step = SP_CMD;
          end
          SP_CMD: begin
            if (lat_write) finish = 1'b1;
            else begin
              go_page  = 1'b1;
              nxt_step = SP_POLL_POST;
            end
          end
          default: finish = 1'b1;
        endcase
      end
      default: ;
    endcase
  end

  assign map_phy = (state == ST_IDLE) ? req_phy : lat_phy;
  assign map_reg = step_reg(nxt_step);

  always_comb begin
    acc_we    = 1'b0;
    acc_wdata = '0;
    case (step)
      SP_ADDR: begin acc_we = 1'b1; acc_wdata = {{(BUS_DW-REG_W){1'b0}}, lat_addr};  end
      SP_DATA: begin acc_we = 1'b1; acc_wdata = {{(BUS_DW-REG_W){1'b0}}, lat_wdata}; end
      SP_CMD:  begin acc_we = 1'b1; acc_wdata = lat_write ? CMD_GO_WR : CMD_GO;      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= SP_POLL_PRE;
      lat_write <= 1'b0;
      lat_phy   <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      step     <= nxt_step;
      if (state == ST_IDLE && req_valid) begin
        lat_write <= req_write;
        lat_phy   <= req_phy;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (go_page) begin
        state     <= ST_PAGE;
        req_ready <= 1'b0;
        bus_req   <= 1'b1;
        bus_we    <= 1'b1;
        bus_addr  <= page_addr;
        bus_wdata <= page_val;
      end else if (go_acc) begin
        state     <= ST_ACC;
        bus_req   <= 1'b1;
        bus_we    <= acc_we;
        bus_addr  <= win_addr;
        bus_wdata <= acc_wdata;
      end else if (finish || fail) begin
        state     <= ST_IDLE;
        req_ready <= 1'b1;
        bus_req   <= 1'b0;
        bus_we    <= 1'b0;
        rsp_done  <= 1'b1;
        rsp_err   <= fail;
        if (step == SP_FETCH) rsp_rdata <= bus_rdata;
      end
    end
  end

  // R10: a raised request holds its fields until acknowledged
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R9: acceptance drops ready and starts bus traffic
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && bus_req));

  // R9: no bus traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_req);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8: error only reported with completion
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done);

  // R2: after a window access completes, any next transaction is a page write
  p_page_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && state == ST_ACC) |=> (!bus_req || bus_we));

endmodule

// File: rtl/phy_indirect_access.sv
module phy_indirect_access
  import phy_indirect_access_pkg::*;
#(
  parameter int                NUM_PHY    = 6,
  parameter int                PHY_W      = $clog2(NUM_PHY),
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE       = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] STRIDE     = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] PAGE_OFS   = 32'h0000_0800,
  parameter int                DEV_STD    = 5,
  parameter int                DEV_ALT    = 31,
  parameter int                ALT_PHY    = 5,
  parameter int                POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);

  logic [PHY_W-1:0]  map_phy;
  logic [REG_W-1:0]  map_reg;
  logic [ADDR_W-1:0] page_addr, win_addr;
  logic [BUS_DW-1:0] page_val;
  logic              tm_clr, tm_busy, tm_at_limit;

  phy_indirect_map #(
    .NUM_PHY (NUM_PHY), .PHY_W (PHY_W), .ADDR_W (ADDR_W),
    .BASE (BASE), .STRIDE (STRIDE), .PAGE_OFS (PAGE_OFS),
    .DEV_STD (DEV_STD), .DEV_ALT (DEV_ALT), .ALT_PHY (ALT_PHY)
  ) u_map (
    .phy_idx   (map_phy),
    .reg_addr  (map_reg),
    .page_addr (page_addr),
    .page_val  (page_val),
    .win_addr  (win_addr)
  );

  phy_indirect_poll_timer #(.LIMIT (POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       (tm_clr),
    .busy_seen (tm_busy),
    .at_limit  (tm_at_limit)
  );

  phy_indirect_seq #(.PHY_W (PHY_W), .ADDR_W (ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_phy     (req_phy),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .map_phy     (map_phy),
    .map_reg     (map_reg),
    .page_addr   (page_addr),
    .page_val    (page_val),
    .win_addr    (win_addr),
    .tm_clr      (tm_clr),
    .tm_busy     (tm_busy),
    .tm_at_limit (tm_at_limit)
  );

endmodule

// File: tb/phy_indirect_access_tb.sv
module phy_indirect_access_tb;

  localparam int          NUM_PHY = 6;
  localparam int          PHY_W   = 3;
  localparam int          LIMIT   = 6;
  localparam logic [31:0] BASE    = 32'hA000_0000;
  localparam int          STRIDE  = 32'h1000;
  localparam int          PG_OFS  = 32'h800;
  localparam logic [15:0] A_CMD   = 16'h80A0;
  localparam logic [15:0] A_ADR   = 16'h80A1;
  localparam logic [15:0] A_DAT   = 16'h80A2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [PHY_W-1:0] req_phy = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #4 clk = ~clk;

  phy_indirect_access #(.NUM_PHY(NUM_PHY), .PHY_W(PHY_W), .BASE(BASE),
                        .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata));

  int n_chk = 0, n_fail = 0;

  task automatic chk(string rq, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // PHY model state
  logic [31:0] page_r [NUM_PHY];
  bit          fresh  [NUM_PHY];
  bit          go_seen[NUM_PHY];
  logic [15:0] areg   [NUM_PHY];
  logic [15:0] dreg   [NUM_PHY];
  int          busy_c [NUM_PHY];
  logic [15:0] phymem [int];
  logic [15:0] refmem [int];
  bit stuck_all = 0, stuck_after_go = 0;
  int busy_time = 10, lat = 0, wc = 0;

  // access log of internal register operations
  bit          lg_we  [$];
  logic [15:0] lg_ia  [$];
  logic [15:0] lg_d   [$];
  bit          lg_busy[$];
  int          lg_p   [$];

  initial begin
    for (int p = 0; p < NUM_PHY; p++) begin
      page_r[p] = '0; fresh[p] = 0; go_seen[p] = 0;
      areg[p] = '0; dreg[p] = '0; busy_c[p] = 0;
    end
  end

  always @(posedge clk) begin
    int p, off, k;
    logic [15:0] ia;
    logic [31:0] rd;
    bus_ack <= 1'b0;
    for (int q = 0; q < NUM_PHY; q++) if (busy_c[q] > 0) busy_c[q]--;
    if (!rst && bus_req && !bus_ack) begin
      if (wc < lat) wc++;
      else begin
        wc = 0;
        bus_ack <= 1'b1;
        rd = '0;
        p   = int'(bus_addr - BASE) / STRIDE;
        off = int'(bus_addr - BASE) % STRIDE;
        if (p >= NUM_PHY) begin
          chk("R3", "bus address in PHY range", p, 0);
          p = 0;
        end
        if (off == PG_OFS) begin
          chk("R2", "page access is a write", bus_we, 1);
          page_r[p] = bus_wdata;
          fresh[p]  = 1;
        end else begin
          chk("R2", "page written before window access", fresh[p], 1);
          fresh[p] = 0;
          chk("R4", "device select", page_r[p][11:7], (p == 5) ? 31 : 5);
          chk("R3", "window offset aligned and below page", (off % 4 == 0 && off < PG_OFS), 1);
          ia = {page_r[p][6:0], off[10:2]};
          k  = p * 65536;
          if (ia == A_CMD) begin
            if (bus_we) begin
              if (bus_wdata[0]) begin
                if (bus_wdata[1]) phymem[k + int'(areg[p])] = dreg[p];
                else dreg[p] = phymem.exists(k + int'(areg[p])) ? phymem[k + int'(areg[p])] : 16'h0;
                busy_c[p]  = busy_time;
                go_seen[p] = 1;
              end
            end else begin
              rd[0] = stuck_all || (stuck_after_go && go_seen[p]) || (busy_c[p] > 0);
            end
          end else if (ia == A_ADR) begin
            if (bus_we) areg[p] = bus_wdata[15:0]; else rd = {16'h0, areg[p]};
          end else if (ia == A_DAT) begin
            if (bus_we) dreg[p] = bus_wdata[15:0]; else rd = {16'h0, dreg[p]};
          end else begin
            if (bus_we) phymem[k + int'(ia)] = bus_wdata[15:0];
            else rd = {16'h0, phymem.exists(k + int'(ia)) ? phymem[k + int'(ia)] : 16'h0};
          end
          lg_we.push_back(bus_we);
          lg_ia.push_back(ia);
          lg_d.push_back(bus_we ? bus_wdata[15:0] : rd[15:0]);
          lg_busy.push_back(rd[0]);
          lg_p.push_back(p);
        end
        bus_rdata <= rd;
      end
    end
  end

  // cycle-by-cycle reference of the handshake
  bit acc_seen = 0, outstanding = 0;
  always @(posedge clk) acc_seen <= !rst && req_valid && req_ready;
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_seen) outstanding = 1;
      if (rsp_done) outstanding = 0;
      chk("R9", "ready equals no request outstanding", req_ready, !outstanding);
      if (!outstanding) chk("R9", "bus quiet while idle", bus_req, 0);
      if (!rsp_done) chk("R9", "err only with done", rsp_err, 0);
    end
  end

  task automatic take_polls(inout int i, input int p, output int n, output int nb);
    n = 0; nb = 0;
    while (i < lg_ia.size() && lg_ia[i] == A_CMD && !lg_we[i]) begin
      n++;
      if (lg_busy[i]) nb++;
      chk("R7", "poll on requested PHY", lg_p[i], p);
      i++;
    end
  endtask

  task automatic expect_op(inout int i, input int p, input bit we, input logic [15:0] ia,
                           input logic [15:0] d, input string rq);
    if (i >= lg_ia.size()) begin
      chk(rq, "missing access", i, lg_ia.size() + 1);
      return;
    end
    chk(rq, "direction", lg_we[i], we);
    chk(rq, "internal address", lg_ia[i], ia);
    chk(rq, "data", lg_d[i], d);
    chk(rq, "phy", lg_p[i], p);
    i++;
  endtask

  // run one request; mode 0 normal, 1 timeout in first poll, 2 timeout in second poll
  task automatic run(input bit wr, input int p, input logic [15:0] a, input logic [15:0] d,
                     input int mode, input bit noise, input int min_pre);
    int i, n, nb, cyc;
    lg_we.delete(); lg_ia.delete(); lg_d.delete(); lg_busy.delete(); lg_p.delete();
    @(negedge clk);
    chk("R9", "ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_phy = PHY_W'(p); req_addr = a; req_wdata = d;
    @(negedge clk);
    chk("R9", "ready drops after accept", req_ready, 0);
    if (noise) begin
      req_write = 1; req_phy = PHY_W'((p + 1) % NUM_PHY); req_addr = 16'h0777; req_wdata = 16'hDEAD;
      repeat (3) @(negedge clk);
    end
    req_valid = 0;
    cyc = 0;
    while (!rsp_done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R9", "completion seen", rsp_done, 1);
    chk("R8", "error flag", rsp_err, mode != 0);
    if (wr && mode == 0) refmem[p * 65536 + int'(a)] = d;
    if (!wr && mode == 0)
      chk("R5", "read data", rsp_rdata,
          {16'h0, refmem.exists(p * 65536 + int'(a)) ? refmem[p * 65536 + int'(a)] : 16'h0});
    i = 0;
    take_polls(i, p, n, nb);
    if (mode == 1) begin
      chk("R8", "busy reads before timeout", n, LIMIT);
      chk("R8", "all timeout reads busy", nb, LIMIT);
    end else begin
      chk("R7", "polls end on first idle read", nb, n - 1);
      if (min_pre > 1) chk("R7", "several polls seen", n >= min_pre, 1);
      expect_op(i, p, 1, A_ADR, a, wr ? "R6" : "R5");
      if (wr) begin
        expect_op(i, p, 1, A_DAT, d, "R6");
        expect_op(i, p, 1, A_CMD, 16'h0003, "R6");
        chk("R6", "done while PHY still busy", busy_c[p] > 0, 1);
      end else begin
        expect_op(i, p, 1, A_CMD, 16'h0001, "R5");
        take_polls(i, p, n, nb);
        if (mode == 2) begin
          chk("R8", "busy reads before timeout", n, LIMIT);
          chk("R8", "all timeout reads busy", nb, LIMIT);
        end else begin
          chk("R7", "second poll ends on idle", nb, n - 1);
          expect_op(i, p, 0, A_DAT, rsp_rdata[15:0], "R5");
        end
      end
    end
    chk(wr ? "R6" : "R5", "no extra accesses", lg_ia.size(), i);
    @(negedge clk);
    chk("R9", "done is one cycle", rsp_done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "req_ready in reset", req_ready, 1);
    chk("R1", "bus_req in reset", bus_req, 0);
    chk("R1", "rsp_done in reset", rsp_done, 0);
    chk("R1", "rsp_err in reset", rsp_err, 0);
    rst = 0;
    run(1, 0, 16'h2004, 16'hBEEF, 0, 1, 0);          // R6 write, R9 noise ignored
    run(0, 0, 16'h2004, 16'h0000, 0, 0, 2);          // R5 read, R7 polls while busy
    lat = 2;
    run(1, 5, 16'h1234, 16'h0A5A, 0, 0, 0);          // R4 alternate device
    run(0, 5, 16'h1234, 16'h0000, 0, 1, 0);
    lat = 0;
    run(1, 2, 16'hFFFF, 16'h7FFF, 0, 0, 0);          // R2 R3 top address bits
    run(0, 2, 16'hFFFF, 16'h0000, 0, 0, 0);
    run(0, 3, 16'h0000, 16'h0000, 0, 0, 0);          // unwritten register
    stuck_all = 1;
    run(0, 1, 16'h0100, 16'h0000, 1, 0, 0);          // R8 first-poll timeout
    run(1, 4, 16'h0100, 16'h1111, 1, 0, 0);
    stuck_all = 0; stuck_after_go = 1;
    for (int q = 0; q < NUM_PHY; q++) go_seen[q] = 0;
    run(0, 4, 16'h0300, 16'h0000, 2, 0, 0);          // R8 second-poll timeout
    for (int q = 0; q < NUM_PHY; q++) go_seen[q] = 0;
    run(1, 1, 16'h0300, 16'h2222, 0, 0, 0);          // R6 write needs no second poll
    stuck_after_go = 0;
    run(0, 1, 16'h0300, 16'h0000, 0, 0, 0);          // R8 normal service after timeout
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule